// File: doc/BRIEF.md
# Deadline-Minimum and Demand-Sum Reduction Node

This block is one inner node of a binary reduction tree used by a hardware task scheduler. It receives two bit-serial frames, one from each child, and sends a single frame to its parent. The command in the frame header sets what the node does. In minimum mode it passes on the smaller of the two deadlines, along with the task identifier that belongs to that deadline. In sum mode it adds the two children's demand-by-deadline partial sums (H) and the two children's demand-by-activation partial sums (G), and passes both totals on.

Each link is four wires wide. Two wires carry the beat type and two carry data. Every payload beat holds one bit per data lane, least significant bit first. The node captures both child frames while it computes bit-serially: a running carry per lane for the sums, and a running comparison for the minimum. On the last payload beat it loads the result into an output shifter. The output header repeats the incoming command without change. The node is one stage in the tree's frame pipeline. The control pair also marks which beats hold valid data. There is no ready signal and the stream cannot be stalled, so the parent must accept one beat every cycle. Frames may follow each other back to back.

Top module: `dlsum_node`

## Requirements
- R1: Beat codes on the control pair are 00 idle, 01 header, 10 payload and 11 final payload. A frame is one header beat followed by PAY_W = BASE_W + clog2(LEAVES+1) payload beats, and the last of these is coded 11. The output uses the same framing. Both children must present their frames on the same cycles.
- R2: The output header appears exactly PAY_W+1 cycles after the input header. Frames may arrive back to back with no idle beat between them, and the node accepts one beat per cycle without back-pressure.
- R3: The output header carries both data bits of the incoming header unchanged.
- R4: Data bit 0 of the header selects the mode, and 0 means minimum. In minimum mode, lane 0 carries the deadline (unsigned, LSB first) and lane 1 carries the identifier. The output lanes are the lanes of the child whose deadline is smaller.
- R5: When the two deadlines are equal, the left child's deadline and identifier are passed on.
- R6: A deadline whose low BASE_W bits are all ones (an idle child) never wins against a smaller deadline. When both children send it, the left child's identifier is passed on.
- R7: In sum mode (header data bit 0 = 1), output lane 0 is H_left + H_right and output lane 1 is G_left + G_right, both modulo 2^PAY_W.
- R8: Any carry out of the top bit of a sum is dropped. It never reaches the next frame.
- R9: During reset and immediately after it, the output control pair is idle and the data pair is 00.
- R10: The node emits exactly one frame for each input frame. During idle beats the output is idle with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_ctl | input | 2 | Beat type from the left child |
| l_dat | input | 2 | Data lanes from the left child |
| r_ctl | input | 2 | Beat type from the right child |
| r_dat | input | 2 | Data lanes from the right child |
| o_ctl | output | 2 | Beat type to the parent |
| o_dat | output | 2 | Data lanes to the parent |

## Verification
The hardest case to reach is a new input header arriving on the same cycle the previous result's header leaves. In that cycle the capture registers, the carry and comparison state, and the output shifter all change hands at once. The stimulus sends the whole minimum sweep and the whole sum sweep as unbroken runs of frames, with only occasional idle gaps, so this overlap happens on almost every frame. It also switches mode from one frame to the next. An overflowing sum is followed at once by a zero sum, which exposes any carry that leaks across the frame boundary. Every pair of four-bit deadlines is tried, so ties and all-ones idle deadlines are covered in full.

// File: rtl/dlsum_pkg.sv
package dlsum_pkg;
  typedef enum logic [1:0] {
    LNK_IDLE = 2'b00,
    LNK_HEAD = 2'b01,
    LNK_BODY = 2'b10,
    LNK_TAIL = 2'b11
  } lnk_ctl_e;

  // header data bit that selects sum mode (0 = minimum mode)
  localparam int MODE_BIT = 0;
endpackage

// File: rtl/dlsum_beat_ctr.sv
module dlsum_beat_ctr #(
  parameter int PAY_W = 20,
  parameter int IDX_W = $clog2(PAY_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head,
  input  logic             body,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  assign last = body && (idx == IDX_W'(PAY_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             idx <= '0;
    else if (head)          idx <= '0;
    else if (body && !last) idx <= idx + 1'b1;
  end
endmodule

// File: rtl/dlsum_serial_add.sv
module dlsum_serial_add (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic a,
  input  logic b,
  output logic s
);
  logic cy_q;

  assign s = a ^ b ^ cy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cy_q <= 1'b0;
    else if (clr) cy_q <= 1'b0;
    else if (en)  cy_q <= (a & b) | (a & cy_q) | (b & cy_q);
  end
endmodule

// File: rtl/dlsum_serial_cmp.sv
module dlsum_serial_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic a,
  input  logic b,
  output logic pick_b
);
  logic pick_q;

  // LSB first: the most significant differing bit seen so far decides
  always_comb begin
    pick_b = pick_q;
    if (en && (a != b)) pick_b = ~b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pick_q <= 1'b0;
    else if (clr) pick_q <= 1'b0;
    else if (en)  pick_q <= pick_b;
  end
endmodule

// File: rtl/dlsum_node.sv
module dlsum_node
  import dlsum_pkg::*;
#(
  parameter int BASE_W = 16,
  parameter int LEAVES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] l_ctl,
  input  logic [1:0] l_dat,
  input  logic [1:0] r_ctl,
  input  logic [1:0] r_dat,
  output logic [1:0] o_ctl,
  output logic [1:0] o_dat
);
  localparam int PAY_W = BASE_W + $clog2(LEAVES + 1);
  localparam int IDX_W = $clog2(PAY_W);
  localparam int CNT_W = $clog2(PAY_W + 1);

  logic             head, body, last;
  logic [IDX_W-1:0] idx;
  logic [1:0]       sum_bit;
  logic             pick_r;
  logic [1:0]       cmd_q;
  logic             mode_q;
  logic [1:0][PAY_W-1:0] lcap, rcap, scap;
  logic [1:0][PAY_W-1:0] lnext, rnext, snext, res;
  logic [1:0][PAY_W-1:0] osh;
  logic [CNT_W-1:0]      ocnt;

  assign head = (l_ctl == LNK_HEAD) && (r_ctl == LNK_HEAD);
  assign body = ((l_ctl == LNK_BODY) || (l_ctl == LNK_TAIL)) &&
                ((r_ctl == LNK_BODY) || (r_ctl == LNK_TAIL));

  dlsum_beat_ctr #(.PAY_W(PAY_W), .IDX_W(IDX_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .head(head), .body(body), .idx(idx), .last(last)
  );

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    dlsum_serial_add u_add (
      .clk(clk), .rst_n(rst_n), .clr(head), .en(body),
      .a(l_dat[ln]), .b(r_dat[ln]), .s(sum_bit[ln])
    );
  end

  dlsum_serial_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .clr(head), .en(body),
    .a(l_dat[0]), .b(r_dat[0]), .pick_b(pick_r)
  );

  // capture images including the beat currently on the link
  always_comb begin
    lnext = lcap;
    rnext = rcap;
    snext = scap;
    if (body) begin
      for (int k = 0; k < 2; k++) begin
        lnext[k][idx] = l_dat[k];
        rnext[k][idx] = r_dat[k];
        snext[k][idx] = sum_bit[k];
      end
    end
  end

  always_comb begin
    if (mode_q)      res = snext;
    else if (pick_r) res = rnext;
    else             res = lnext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      mode_q <= 1'b0;
      lcap   <= '0;
      rcap   <= '0;
      scap   <= '0;
    end else begin
      if (head) begin
        cmd_q  <= l_dat;
        mode_q <= l_dat[MODE_BIT];
      end
      if (body) begin
        lcap <= lnext;
        rcap <= rnext;
        scap <= snext;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_ctl <= LNK_IDLE;
      o_dat <= '0;
      osh   <= '0;
      ocnt  <= '0;
    end else if (last) begin
      o_ctl <= LNK_HEAD;
      o_dat <= cmd_q;
      osh   <= res;
      ocnt  <= CNT_W'(PAY_W);
    end else if (ocnt != '0) begin
      o_ctl  <= (ocnt == CNT_W'(1)) ? LNK_TAIL : LNK_BODY;
      o_dat  <= {osh[1][0], osh[0][0]};
      osh[0] <= osh[0] >> 1;
      osh[1] <= osh[1] >> 1;
      ocnt   <= ocnt - 1'b1;
    end else begin
      o_ctl <= LNK_IDLE;
      o_dat <= '0;
    end
  end
endmodule

// File: rtl/dlsum_node_chk.sv
module dlsum_node_chk
  import dlsum_pkg::*;
#(
  parameter int BASE_W = 16,
  parameter int LEAVES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] l_ctl,
  input logic [1:0] l_dat,
  input logic [1:0] r_ctl,
  input logic [1:0] o_ctl,
  input logic [1:0] o_dat
);
  localparam int PAY_W = BASE_W + $clog2(LEAVES + 1);
  localparam int AGE_W = $clog2(PAY_W + 2);

  logic             pend;
  logic [AGE_W-1:0] age;
  logic [AGE_W-1:0] oc;
  logic [1:0]       held_cmd;
  logic             in_head;

  assign in_head = (l_ctl == LNK_HEAD) && (r_ctl == LNK_HEAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; age <= '0; held_cmd <= '0; oc <= '0;
    end else begin
      if (in_head) begin
        pend <= 1'b1; age <= AGE_W'(1); held_cmd <= l_dat;
      end else if (pend) begin
        if (age == AGE_W'(PAY_W + 1)) pend <= 1'b0;
        else                          age  <= age + 1'b1;
      end
      if (o_ctl == LNK_HEAD) oc <= '0;
      else if (o_ctl == LNK_BODY || o_ctl == LNK_TAIL) oc <= oc + 1'b1;
    end
  end

  p_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    l_ctl == r_ctl);
  p_tail_pos_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ctl == LNK_TAIL) |-> (oc == AGE_W'(PAY_W - 1)));
  p_body_pos_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ctl == LNK_BODY) |-> (oc < AGE_W'(PAY_W - 1)));
  p_head_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ctl == LNK_HEAD) |-> (pend && age == AGE_W'(PAY_W + 1)));
  p_head_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && age == AGE_W'(PAY_W + 1)) |-> (o_ctl == LNK_HEAD));
  p_cmd_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ctl == LNK_HEAD) |-> (o_dat == held_cmd));
  p_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (o_ctl == LNK_IDLE && o_dat == 2'b00));
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ctl == LNK_IDLE) |-> (o_dat == 2'b00));
endmodule

bind dlsum_node dlsum_node_chk #(.BASE_W(BASE_W), .LEAVES(LEAVES)) u_chk (
  .clk(clk), .rst_n(rst_n), .l_ctl(l_ctl), .l_dat(l_dat),
  .r_ctl(r_ctl), .o_ctl(o_ctl), .o_dat(o_dat)
);

// File: tb/dlsum_node_tb.sv
`timescale 1ns/1ps
module dlsum_node_tb;
  localparam int BASE_W = 4;
  localparam int LEAVES = 4;
  localparam int P      = BASE_W + $clog2(LEAVES + 1);
  localparam int MAXF   = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] l_ctl = '0, l_dat = '0, r_ctl = '0, r_dat = '0;
  logic [1:0] o_ctl, o_dat;

  dlsum_node #(.BASE_W(BASE_W), .LEAVES(LEAVES)) u_dut (
    .clk(clk), .rst_n(rst_n), .l_ctl(l_ctl), .l_dat(l_dat),
    .r_ctl(r_ctl), .r_dat(r_dat), .o_ctl(o_ctl), .o_dat(o_dat)
  );

  always #4 clk = ~clk;

  int     nchk = 0, nfail = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [P-1:0] exp0 [MAXF];
  logic [P-1:0] exp1 [MAXF];
  logic [1:0]   exp_cmd [MAXF];
  longint       tx_cyc [MAXF];
  string        exp_req [MAXF];
  int           ntx = 0, nrx = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic send(input logic [1:0] cmd,
                      input logic [P-1:0] l0, input logic [P-1:0] l1,
                      input logic [P-1:0] r0, input logic [P-1:0] r1,
                      input logic [P-1:0] e0, input logic [P-1:0] e1,
                      input string req);
    @(negedge clk);
    exp0[ntx] = e0; exp1[ntx] = e1; exp_cmd[ntx] = cmd;
    exp_req[ntx] = req; tx_cyc[ntx] = cyc; ntx++;
    l_ctl = 2'b01; r_ctl = 2'b01; l_dat = cmd; r_dat = cmd;
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      l_ctl = (k == P-1) ? 2'b11 : 2'b10;
      r_ctl = l_ctl;
      l_dat = {l1[k], l0[k]};
      r_dat = {r1[k], r0[k]};
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      l_ctl = 2'b00; r_ctl = 2'b00; l_dat = 2'b00; r_dat = 2'b00;
    end
  endtask

  // output monitor
  bit           busy = 0;
  int           bcnt = 0;
  logic [1:0]   got_cmd;
  longint       hcyc;
  logic [P-1:0] g0, g1;
  int           idle_bad = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (o_ctl == 2'b01) begin
        check(!busy, "R1", "header inside frame", 1, 0);
        busy = 1; bcnt = 0; got_cmd = o_dat; hcyc = cyc; g0 = '0; g1 = '0;
      end else if (o_ctl == 2'b10 || o_ctl == 2'b11) begin
        if (bcnt < P) begin g0[bcnt] = o_dat[0]; g1[bcnt] = o_dat[1]; end
        bcnt++;
        if (o_ctl == 2'b11) begin
          check(bcnt == P, "R1", "payload length", bcnt, P);
          if (nrx < ntx) begin
            check(hcyc - tx_cyc[nrx] == P + 1, "R2", "header latency",
                  hcyc - tx_cyc[nrx], P + 1);
            check(got_cmd == exp_cmd[nrx], "R3", "forwarded command",
                  got_cmd, exp_cmd[nrx]);
            check(g0 == exp0[nrx], exp_req[nrx], "lane0", g0, exp0[nrx]);
            check(g1 == exp1[nrx], exp_req[nrx], "lane1", g1, exp1[nrx]);
          end else begin
            check(0, "R10", "unexpected frame", nrx, ntx);
          end
          nrx++; busy = 0;
        end
      end else if (o_dat != 2'b00) begin
        idle_bad++;
      end
    end
  end

  bit done = 0;
  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(o_ctl == 2'b00, "R9", "ctl in reset", o_ctl, 0);
    check(o_dat == 2'b00, "R9", "dat in reset", o_dat, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(o_ctl == 2'b00 && o_dat == 2'b00, "R9", "after reset", {o_ctl, o_dat}, 0);
    idle(10);
    check(nrx == 0 && o_ctl == 2'b00, "R10", "no frame from idle", nrx, 0);

    // minimum mode: all deadline pairs, back to back
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [P-1:0] lid, rid, da, db;
        string tag;
        lid = P'((a ^ 1) & 3); rid = lid ^ P'(3);
        da = P'(a); db = P'(b);
        if (a == b) tag = "R5";
        else if (a == 15 || b == 15) tag = "R6";
        else tag = "R4";
        if (b < a) send({a[0], 1'b0}, da, lid, db, rid, db, rid, tag);
        else       send({a[0], 1'b0}, da, lid, db, rid, da, lid, tag);
      end
      if (a % 5 == 4) idle(a % 3 + 1);
    end

    // sum mode sweep
    for (int i = 0; i < 240; i++) begin
      logic [P-1:0] hl, hr, gl, gr;
      hl = P'(i * 37 + 5); hr = P'(i * 91 + 17);
      gl = P'(i * 13);     gr = P'(i * 59 + 3);
      send({i[0], 1'b1}, hl, gl, hr, gr, hl + hr, gl + gr, "R7");
      if (i % 50 == 49) idle(2);
    end

    // carry must not leak across frames; mode switches back to back
    send(2'b01, '1, '1, P'(1), '1, '0, '1 - P'(1), "R8");
    send(2'b01, '0, '0, '0, '0, '0, '0, "R8");
    send(2'b00, P'(3), P'(1), P'(2), P'(2), P'(2), P'(2), "R4");
    send(2'b11, P'(1), P'(0), P'(0), P'(0), P'(1), P'(0), "R8");
    idle(P + 4);
    check(nrx == ntx, "R10", "frame count", nrx, ntx);
    check(idle_bad == 0, "R10", "idle data nonzero", idle_bad, 0);
    check(o_ctl == 2'b00, "R10", "idle after traffic", o_ctl, 0);
    finish_up();
  end
endmodule